// File: doc/BRIEF.md
# Column command and data-bus timing tracker

This block is shared by all banks of a DRAM channel controller. It watches the column read and column write commands that the scheduler issues and works out, cycle by cycle, whether another read or another write may be issued now. It also marks the cycles in which read data is expected on the data bus and the cycles in which the controller must drive write data. Row timing, refresh and the data path itself are handled elsewhere.

Each accepted command places a transfer window into a small queue of pending transfers. Each entry counts down to the start of its window and then counts its beats. Before a new command is accepted, its future window is compared with every pending window, so the data bus never carries a read and a write at once, and transfers in the same direction never overlap. Column-to-column spacing, command-bus occupancy and write-to-read turnaround are enforced by saturating counters. All timing values are captured from configuration inputs while a configuration enable is high.

Timing convention: a command is accepted at clock edge e when its strobe and the matching allowed flag are both high in the cycle before e. A window of latency L and length B covers the B cycles that start right after edge e+L.

Top module: `col_bus_timer`

## Requirements
- R1: At a clock edge where cfg_en_i is high, all cfg_* inputs are captured. At every other edge the captured values are held, whatever the cfg_* inputs do. Reset sets all captured values to zero.
- R2: A read accepted at edge e drives rd_vld_o high for exactly max(burst,1) cycles, starting right after edge e+cas, where cas is the captured read latency.
- R3: A write accepted at edge e drives wr_drv_o high for max(burst,1) cycles, starting right after edge e+wl. The write latency wl is chosen by cfg_cwd_sel_i: 0 selects zero, 1 selects one, 2 selects cas-1 (zero when cas is zero), and 3 selects cfg_cwd_i.
- R4: After a command is accepted at edge p, both allowed flags stay low until edge p+max(ccd,cmd,1) can accept, where ccd is the column spacing and cmd is the command-bus occupancy.
- R5: A command is refused if its window would overlap any pending window, read or write. A burst longer than ccd therefore limits the spacing.
- R6: A read is refused while any write is pending. It is also refused until edge x+max(wtr,1), where edge x ends the last beat of the most recent write.
- R7: A strobe given while its allowed flag is low is ignored. If both strobes are accepted in the same cycle, the read is taken and the write is ignored.
- R8: When DEPTH transfers are pending, both allowed flags are low.
- R9: After reset, both windows are low and both allowed flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Capture the timing values at this edge |
| cfg_cas_i | input | T_W | Read latency |
| cfg_cwd_sel_i | input | 2 | Write latency select: 0 zero, 1 one, 2 cas-1, 3 programmed |
| cfg_cwd_i | input | T_W | Programmed write latency |
| cfg_burst_i | input | T_W | Burst length on the bus (0 acts as 1) |
| cfg_ccd_i | input | T_W | Minimum column command spacing |
| cfg_cmd_i | input | T_W | Command-bus occupancy per command |
| cfg_wtr_i | input | T_W | Write-end to read turnaround |
| rd_i | input | 1 | Column read strobe |
| wr_i | input | 1 | Column write strobe |
| rd_ok_o | output | 1 | A read may be issued in this cycle |
| wr_ok_o | output | 1 | A write may be issued in this cycle |
| rd_vld_o | output | 1 | Read data is on the bus |
| wr_drv_o | output | 1 | Write data must be driven |

## Verification
A countdown in the queue that is off by one moves a data window by a cycle. This shows at rd_vld_o or wr_drv_o as soon as that transfer starts, which is at most cas or wl cycles after its command. A stuck or misloaded spacing or turnaround counter shows as an allowed flag that differs from the arithmetic expectation in the very next cycle in which the limit matters. The bench sweeps every combination of read latency, write-latency select, burst, spacing and turnaround in a small range, with random strobes, and compares all four outputs in every cycle.

// File: rtl/col_timer_pkg.sv
package col_timer_pkg;
  parameter int unsigned TIME_W = 6;
  typedef enum logic [1:0] {CWD_ZERO, CWD_ONE, CWD_CAS_M1, CWD_PROG} cwd_sel_e;
endpackage

// File: rtl/col_cfg_regs.sv
module col_cfg_regs #(
  parameter int unsigned T_W = col_timer_pkg::TIME_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_en_i,
  input  logic [T_W-1:0] cas_i,
  input  logic [1:0]     cwd_sel_i,
  input  logic [T_W-1:0] cwd_i,
  input  logic [T_W-1:0] burst_i,
  input  logic [T_W-1:0] ccd_i,
  input  logic [T_W-1:0] cmd_i,
  input  logic [T_W-1:0] wtr_i,
  output logic [T_W-1:0] cas_o,
  output logic [T_W-1:0] cwd_o,
  output logic [T_W-1:0] burst_o,
  output logic [T_W-1:0] gap_o,
  output logic [T_W-1:0] wtr_o
);
  import col_timer_pkg::*;
  logic [T_W-1:0] cas_q, cwd_q, burst_q, ccd_q, cmd_q, wtr_q;
  cwd_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_q <= '0; cwd_q <= '0; burst_q <= '0;
      ccd_q <= '0; cmd_q <= '0; wtr_q <= '0;
      sel_q <= CWD_ZERO;
    end else if (cfg_en_i) begin
      cas_q <= cas_i; cwd_q <= cwd_i; burst_q <= burst_i;
      ccd_q <= ccd_i; cmd_q <= cmd_i; wtr_q <= wtr_i;
      sel_q <= cwd_sel_e'(cwd_sel_i);
    end
  end

  always_comb begin
    unique case (sel_q)
      CWD_ZERO:   cwd_o = '0;
      CWD_ONE:    cwd_o = T_W'(1);
      CWD_CAS_M1: cwd_o = (cas_q == '0) ? '0 : cas_q - T_W'(1);
      default:    cwd_o = cwd_q;
    endcase
  end

  assign cas_o   = cas_q;
  assign burst_o = (burst_q == '0) ? T_W'(1) : burst_q;
  assign gap_o   = (ccd_q > cmd_q) ? ccd_q : cmd_q;
  assign wtr_o   = wtr_q;
endmodule

// File: rtl/col_xfer_queue.sv
module col_xfer_queue #(
  parameter int unsigned T_W   = col_timer_pkg::TIME_W,
  parameter int unsigned DEPTH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           push_wr_i,
  input  logic [T_W-1:0] rd_lat_i,
  input  logic [T_W-1:0] wr_lat_i,
  input  logic [T_W-1:0] burst_i,
  output logic           rd_vld_o,
  output logic           wr_drv_o,
  output logic           full_o,
  output logic           wr_pend_o,
  output logic           wr_end_o,
  output logic           rd_clash_o,
  output logic           wr_clash_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned SUM_W = T_W + 1;

  logic [DEPTH-1:0] vld_q, wr_q, act, last, ov_rd, ov_wr;
  logic [T_W-1:0]   dly_q [DEPTH];
  logic [T_W-1:0]   len_q [DEPTH];
  logic [IDX_W-1:0] ins_idx;
  logic [SUM_W-1:0] rd_lo, rd_hi, wr_lo, wr_hi;

  always_comb begin
    ins_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) ins_idx = IDX_W'(i);
  end

  assign rd_lo = SUM_W'(rd_lat_i);
  assign rd_hi = SUM_W'(rd_lat_i) + SUM_W'(burst_i);
  assign wr_lo = SUM_W'(wr_lat_i);
  assign wr_hi = SUM_W'(wr_lat_i) + SUM_W'(burst_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [SUM_W-1:0] s_rel, e_rel;
    // window of this entry seen from the next edge: [s_rel, e_rel)
    assign s_rel = (dly_q[g] != '0) ? SUM_W'(dly_q[g]) - SUM_W'(1) : '0;
    assign e_rel = (dly_q[g] != '0) ? SUM_W'(dly_q[g]) - SUM_W'(1) + SUM_W'(len_q[g])
                                    : SUM_W'(len_q[g]) - SUM_W'(1);
    assign act[g]   = vld_q[g] && (dly_q[g] == '0);
    assign last[g]  = act[g] && (len_q[g] == T_W'(1));
    assign ov_rd[g] = vld_q[g] && (rd_lo < e_rel) && (s_rel < rd_hi);
    assign ov_wr[g] = vld_q[g] && (wr_lo < e_rel) && (s_rel < wr_hi);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        wr_q[g]  <= 1'b0;
        dly_q[g] <= '0;
        len_q[g] <= '0;
      end else if (push_i && !vld_q[g] && (ins_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        wr_q[g]  <= push_wr_i;
        dly_q[g] <= push_wr_i ? wr_lat_i : rd_lat_i;
        len_q[g] <= burst_i;
      end else if (vld_q[g]) begin
        if (dly_q[g] != '0)          dly_q[g] <= dly_q[g] - T_W'(1);
        else if (len_q[g] == T_W'(1)) vld_q[g] <= 1'b0;
        else                          len_q[g] <= len_q[g] - T_W'(1);
      end
    end
  end

  assign rd_vld_o   = |(act & ~wr_q);
  assign wr_drv_o   = |(act & wr_q);
  assign full_o     = &vld_q;
  assign wr_pend_o  = |(vld_q & wr_q);
  assign wr_end_o   = |(last & wr_q);
  assign rd_clash_o = |ov_rd;
  assign wr_clash_o = |ov_wr;
endmodule

// File: rtl/col_gap_track.sv
module col_gap_track #(
  parameter int unsigned T_W = col_timer_pkg::TIME_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_go_i,
  input  logic           wr_end_i,
  input  logic [T_W-1:0] gap_lim_i,
  input  logic [T_W-1:0] wtr_i,
  output logic           cmd_room_o,
  output logic           wtr_room_o
);
  localparam logic [T_W-1:0] SAT = '1;
  logic [T_W-1:0] since_cmd_q, since_wr_q;

  // both count edges up to the next one, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_cmd_q <= SAT;
      since_wr_q  <= SAT;
    end else begin
      if (cmd_go_i)                 since_cmd_q <= T_W'(1);
      else if (since_cmd_q != SAT)  since_cmd_q <= since_cmd_q + T_W'(1);
      if (wr_end_i)                 since_wr_q  <= T_W'(1);
      else if (since_wr_q != SAT)   since_wr_q  <= since_wr_q + T_W'(1);
    end
  end

  assign cmd_room_o = since_cmd_q >= gap_lim_i;
  assign wtr_room_o = since_wr_q >= wtr_i;
endmodule

// File: rtl/col_bus_timer.sv
module col_bus_timer #(
  parameter int unsigned T_W   = col_timer_pkg::TIME_W,
  parameter int unsigned DEPTH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_en_i,
  input  logic [T_W-1:0] cfg_cas_i,
  input  logic [1:0]     cfg_cwd_sel_i,
  input  logic [T_W-1:0] cfg_cwd_i,
  input  logic [T_W-1:0] cfg_burst_i,
  input  logic [T_W-1:0] cfg_ccd_i,
  input  logic [T_W-1:0] cfg_cmd_i,
  input  logic [T_W-1:0] cfg_wtr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  output logic           rd_ok_o,
  output logic           wr_ok_o,
  output logic           rd_vld_o,
  output logic           wr_drv_o
);
  logic [T_W-1:0] cas_q, cwd_q, burst_q, gap_q, wtr_q;
  logic full, wr_pend, wr_end, rd_clash, wr_clash, cmd_room, wtr_room;
  logic rd_go, wr_go;

  col_cfg_regs #(.T_W(T_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_en_i,
    .cas_i(cfg_cas_i), .cwd_sel_i(cfg_cwd_sel_i), .cwd_i(cfg_cwd_i),
    .burst_i(cfg_burst_i), .ccd_i(cfg_ccd_i), .cmd_i(cfg_cmd_i), .wtr_i(cfg_wtr_i),
    .cas_o(cas_q), .cwd_o(cwd_q), .burst_o(burst_q), .gap_o(gap_q), .wtr_o(wtr_q)
  );

  col_xfer_queue #(.T_W(T_W), .DEPTH(DEPTH)) u_q (
    .clk_i, .rst_ni,
    .push_i(rd_go | wr_go), .push_wr_i(wr_go),
    .rd_lat_i(cas_q), .wr_lat_i(cwd_q), .burst_i(burst_q),
    .rd_vld_o, .wr_drv_o, .full_o(full), .wr_pend_o(wr_pend), .wr_end_o(wr_end),
    .rd_clash_o(rd_clash), .wr_clash_o(wr_clash)
  );

  col_gap_track #(.T_W(T_W)) u_gap (
    .clk_i, .rst_ni, .cmd_go_i(rd_go | wr_go), .wr_end_i(wr_end),
    .gap_lim_i(gap_q), .wtr_i(wtr_q),
    .cmd_room_o(cmd_room), .wtr_room_o(wtr_room)
  );

  assign rd_ok_o = cmd_room && !full && !rd_clash && !wr_pend && wtr_room;
  assign wr_ok_o = cmd_room && !full && !wr_clash;
  assign rd_go   = rd_i && rd_ok_o;
  assign wr_go   = wr_i && wr_ok_o && !rd_go;  // R7 read wins
endmodule

// File: rtl/col_bus_timer_chk.sv
module col_bus_timer_chk #(
  parameter int unsigned T_W = col_timer_pkg::TIME_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_en_i,
  input logic           rd_i,
  input logic           wr_i,
  input logic           rd_ok_o,
  input logic           wr_ok_o,
  input logic           rd_vld_o,
  input logic           wr_drv_o,
  input logic [T_W-1:0] cas_q,
  input logic [T_W-1:0] cwd_q,
  input logic [T_W-1:0] gap_q
);
  logic rd_acc, wr_acc;
  assign rd_acc = rd_i && rd_ok_o;
  assign wr_acc = wr_i && wr_ok_o && !rd_acc;

  a_r5_bus_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_vld_o && wr_drv_o));

  a_r6_no_read_under_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drv_o |-> !rd_ok_o);

  a_r4_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_acc || wr_acc) && gap_q > T_W'(1) && !cfg_en_i) |=> (!rd_ok_o && !wr_ok_o));

  a_r2_zero_lat_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && cas_q == '0 && !cfg_en_i) |=> rd_vld_o);

  a_r3_zero_lat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && cwd_q == '0 && !cfg_en_i) |=> wr_drv_o);
endmodule

bind col_bus_timer col_bus_timer_chk #(.T_W(T_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .rd_i(rd_i), .wr_i(wr_i),
  .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .rd_vld_o(rd_vld_o), .wr_drv_o(wr_drv_o),
  .cas_q(cas_q), .cwd_q(cwd_q), .gap_q(gap_q)
);

// File: tb/sim_col_bus_timer.sv
`timescale 1ns/1ps
module sim_col_bus_timer;
  localparam int T_W = 6;
  localparam int DEPTH = 4;
  localparam int NW = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, cfg_en_i = 1'b0;
  logic [T_W-1:0] cfg_cas_i = '0, cfg_cwd_i = '0, cfg_burst_i = '0;
  logic [T_W-1:0] cfg_ccd_i = '0, cfg_cmd_i = '0, cfg_wtr_i = '0;
  logic [1:0] cfg_cwd_sel_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic rd_ok_o, wr_ok_o, rd_vld_o, wr_drv_o;

  always #4 clk_i = ~clk_i;

  col_bus_timer #(.T_W(T_W), .DEPTH(DEPTH)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int edge_n = 0;
  int m_cas = 0, m_cwd = 0, m_b = 1, m_gap = 1, m_wtr = 1;
  int last_cmd = -1000;
  int ws[NW], wl[NW];
  bit ww[NW], wv[NW];
  int wn = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0b expected %0b", tag, what, edge_n, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit clash(input int n, input int lat);
    for (int i = 0; i < NW; i++)
      if (wv[i] && n + lat < ws[i] + wl[i] && ws[i] < n + lat + m_b) return 1;
    return 0;
  endfunction

  // one cycle: check outputs, drive strobes, advance the model
  task automatic step(input bit rd, input bit wr);
    int y, n, pend;
    bit gap_ok, full, wtr_ok, e_rd_ok, e_wr_ok, e_vld, e_drv, rd_acc, wr_acc;
    string rtag, wtag;
    y = edge_n; n = y + 1;
    pend = 0; wtr_ok = 1; e_vld = 0; e_drv = 0;
    for (int i = 0; i < NW; i++) if (wv[i]) begin
      if (y < ws[i] + wl[i]) pend++;
      if (ww[i] && n < ws[i] + wl[i] + mx(m_wtr, 1)) wtr_ok = 0;
      if (ws[i] <= y && y < ws[i] + wl[i]) begin
        if (ww[i]) e_drv = 1; else e_vld = 1;
      end
    end
    gap_ok = (n - last_cmd) >= mx(m_gap, 1);
    full = pend >= DEPTH;
    e_rd_ok = gap_ok && !full && wtr_ok && !clash(n, m_cas);
    e_wr_ok = gap_ok && !full && !clash(n, m_cwd);
    rtag = full ? "R8" : !gap_ok ? "R4" : !wtr_ok ? "R6" : "R5";
    wtag = full ? "R8" : !gap_ok ? "R4" : "R5";
    chk(rd_vld_o, e_vld, "R2", "rd_vld_o");
    chk(wr_drv_o, e_drv, "R3", "wr_drv_o");
    chk(rd_ok_o, e_rd_ok, rtag, "rd_ok_o");
    chk(wr_ok_o, e_wr_ok, wtag, "wr_ok_o");
    rd_i = rd; wr_i = wr;
    rd_acc = rd && e_rd_ok;              // R7: refused strobes leave no window
    wr_acc = wr && e_wr_ok && !rd_acc;   // R7: read wins
    @(posedge clk_i);
    edge_n++;
    if (rd_acc || wr_acc) begin
      wv[wn] = 1; ww[wn] = wr_acc; wl[wn] = m_b;
      ws[wn] = edge_n + (wr_acc ? m_cwd : m_cas);
      wn = (wn + 1) % NW;
      last_cmd = edge_n;
    end
    @(negedge clk_i);
    rd_i = 0; wr_i = 0;
  endtask

  task automatic load_cfg(input int cas, input int sel, input int cwd, input int b,
                          input int ccd, input int cmd, input int wtr);
    cfg_cas_i = T_W'(cas); cfg_cwd_sel_i = 2'(sel); cfg_cwd_i = T_W'(cwd);
    cfg_burst_i = T_W'(b); cfg_ccd_i = T_W'(ccd); cfg_cmd_i = T_W'(cmd); cfg_wtr_i = T_W'(wtr);
    cfg_en_i = 1;
    step(0, 0);
    cfg_en_i = 0;
    m_cas = cas; m_b = mx(b, 1); m_gap = mx(ccd, cmd); m_wtr = wtr;
    case (sel)
      0: m_cwd = 0;
      1: m_cwd = 1;
      2: m_cwd = (cas == 0) ? 0 : cas - 1;
      default: m_cwd = cwd;
    endcase
    // R1: inputs moved without enable must not matter
    cfg_cas_i = T_W'(cas + 5); cfg_cwd_sel_i = 2'(sel + 1); cfg_burst_i = T_W'(b + 2);
    cfg_ccd_i = T_W'(7); cfg_cmd_i = T_W'(6); cfg_wtr_i = T_W'(9); cfg_cwd_i = T_W'(3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) wv[i] = 0;
    #20 rst_ni = 1;
    @(negedge clk_i);
    // R9 reset state
    chk(rd_ok_o, 1, "R9", "rd_ok_o after reset");
    chk(wr_ok_o, 1, "R9", "wr_ok_o after reset");
    chk(rd_vld_o, 0, "R9", "rd_vld_o after reset");
    chk(wr_drv_o, 0, "R9", "wr_drv_o after reset");
    // R1 reset values: zero latency, burst 1
    step(1, 0);
    step(0, 1);
    for (int k = 0; k < 6; k++) step(0, 0);
    for (int cas = 0; cas < 4; cas++)
      for (int sel = 0; sel < 4; sel++)
        for (int b = 1; b < 4; b++)
          for (int ci = 0; ci < 2; ci++)
            for (int wi = 0; wi < 2; wi++) begin
              for (int k = 0; k < 16; k++) step(0, 0);
              load_cfg(cas, sel, (cas + 2 * b) % 5, b, ci * 2 + 1, (cas + b) % 3, wi * 2);
              for (int k = 0; k < 56; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[2:0] < 3'd3, lfsr[5:3] < 3'd3);
              end
            end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule